// File: doc/BRIEF.md
# Serial Configuration PROM Loader

This block fetches a device's start-up settings over a three-wire serial link right after reset. The far end is a small serial EEPROM, or a host that answers as one. The block has no chip-select pin. It issues a single read command with start address zero. It then keeps clocking until six bytes have streamed back.

The first byte received must be the head marker 0xBD and the sixth must be the tail marker 0x99. The four bytes in between carry the settings. When both markers match, the decoded settings are applied together. Otherwise every setting falls back to its default value.

The serial clock is derived from the reference clock by a prescaler. Command bits change on falling serial-clock edges, and reply bits are captured on rising edges. The data line is split into a driven value and an output enable for the pad ring. A one-cycle done pulse marks the end of the load, and a level flag tells whether loaded values or defaults are in force.

Top module: `cfg_prom_loader`

## Requirements
- R1: While `rst_n` is low, and from the first reference cycle it is low, `sclk`, `sdo_oe`, `load_done` and `load_valid` are 0 and every setting holds its default: pre-emphasis delay 000, dedicated return link disable 1, embedded return link disable 1, full bandwidth 0, post-load wait 1, pixel width 00, control transmit mode 11, rising pixel edge 1, return line clock select 10, data recovery 0001, error pin mode 000, PLL-loss reset disable 0.
- R2: The first rising edge of `sclk` comes no sooner than START_WAIT reference cycles after `rst_n` is released.
- R3: While the transfer runs, every high phase and every low phase between two `sclk` pulses lasts exactly HALF_DIV reference cycles.
- R4: The block drives eleven command bits, most significant first: a start bit 1, the read opcode 1 0, and eight address zeros. `sdo_oe` is 1 for all of them, and `sdo` changes only while `sclk` is low, so each bit is stable at its rising edge.
- R5: `sdo_oe` drops at the falling `sclk` edge that ends the last command bit and stays 0 for all 48 reply bits.
- R6: Reply bits are captured on rising `sclk` edges, most significant bit first. The bytes arrive in the order head marker, setting bytes 1 to 4, tail marker.
- R7: If the head marker is 0xBD and the tail marker is 0x99, `load_valid` becomes 1 and the settings are taken from the bytes as follows.
  - Byte 1: [2:0] pre-emphasis delay, [3] dedicated return link disable, [4] embedded return link disable, [6] full bandwidth, [7] post-load wait.
  - Byte 2: [1:0] pixel width, [3:2] control transmit mode, [5] rising pixel edge, [7:6] return line clock select.
  - Byte 3: [3:0] data recovery, [7:5] error pin mode.
  - Byte 4: [0] PLL-loss reset disable.
- R8: If either marker differs from its expected value, every setting takes its R1 default and `load_valid` is 0.
- R9: `load_done` is a single-cycle pulse that occurs exactly once per reset. It comes in the same cycle as the settings and `load_valid` take their final values.
- R10: The settings and `load_valid` do not change at any point of the load except with `load_done`. After the load, `sclk` rests low and `sdo_oe` stays 0.
- R11: Asserting `rst_n` in the middle of a load returns the block at once to the R1 state, and the next release starts a fresh load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | output | 1 | Serial clock to the PROM |
| sdo | output | 1 | Serial data value driven toward the PROM |
| sdo_oe | output | 1 | Output enable for the shared data pad |
| sdi | input | 1 | Serial data returned by the PROM |
| load_done | output | 1 | One-cycle pulse at the end of the load |
| load_valid | output | 1 | 1 when loaded settings are in force, 0 for defaults |
| cfg_pre_delay | output | 3 | Pre-emphasis onset delay |
| cfg_up_ded_n | output | 1 | Dedicated return link disable |
| cfg_up_emb_n | output | 1 | Embedded return link disable |
| cfg_bw_full | output | 1 | Full link bandwidth select |
| cfg_wait_en | output | 1 | Post-load settling wait enable |
| cfg_px_width | output | 2 | Pixel data width code |
| cfg_ctrl_mode | output | 2 | Pixel control transmit mode |
| cfg_clk_rise | output | 1 | Sample pixels on the rising edge |
| cfg_up_clk_sel | output | 2 | Return line clock select |
| cfg_recov | output | 4 | Return link data recovery setting |
| cfg_err_mode | output | 3 | Error pin mode |
| cfg_pll_rst_dis | output | 1 | Disable reset on PLL loss |

## Verification
The result of a load is due one reference cycle after the rising `sclk` edge that captures the 48th reply bit. That edge registers both the last bit and a capture strobe, and the next edge updates `load_done`, `load_valid` and the settings together. The scoreboard therefore pops its expected entry only on a falling reference edge where `load_done` is high, and compares all settings and the flag in that one cycle. The bench's PROM model acts a few nanoseconds after each `sclk` edge: it reads command bits after rising edges and drives reply bits after falling edges, so every value is half a serial period from the capture that uses it. Reset, phase-length and start-delay checks are all sampled on falling reference edges.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int FRAME_BYTES = 6;
  localparam int FRAME_BITS  = FRAME_BYTES * 8;
  localparam int CMD_BITS    = 11;

  // start bit, read opcode, address zero
  localparam logic [CMD_BITS-1:0] READ_CMD = 11'b1_10_0000_0000;

  localparam logic [7:0] MARK_HEAD = 8'hBD;
  localparam logic [7:0] MARK_TAIL = 8'h99;

  typedef struct packed {
    logic [2:0] pre_delay;
    logic       up_ded_n;
    logic       up_emb_n;
    logic       bw_full;
    logic       wait_en;
    logic [1:0] px_width;
    logic [1:0] ctrl_mode;
    logic       clk_rise;
    logic [1:0] up_clk_sel;
    logic [3:0] recov;
    logic [2:0] err_mode;
    logic       pll_rst_dis;
  } cfg_fields_t;

  localparam cfg_fields_t CFG_DEFAULT = '{
    pre_delay:   3'b000,
    up_ded_n:    1'b1,
    up_emb_n:    1'b1,
    bw_full:     1'b0,
    wait_en:     1'b1,
    px_width:    2'b00,
    ctrl_mode:   2'b11,
    clk_rise:    1'b1,
    up_clk_sel:  2'b10,
    recov:       4'b0001,
    err_mode:    3'b000,
    pll_rst_dis: 1'b0
  };

  function automatic cfg_fields_t decode_cfg(input logic [7:0] b1,
                                             input logic [7:0] b2,
                                             input logic [7:0] b3,
                                             input logic [7:0] b4);
    cfg_fields_t f;
    f.pre_delay   = b1[2:0];
    f.up_ded_n    = b1[3];
    f.up_emb_n    = b1[4];
    f.bw_full     = b1[6];
    f.wait_en     = b1[7];
    f.px_width    = b2[1:0];
    f.ctrl_mode   = b2[3:2];
    f.clk_rise    = b2[5];
    f.up_clk_sel  = b2[7:6];
    f.recov       = b3[3:0];
    f.err_mode    = b3[7:5];
    f.pll_rst_dis = b4[0];
    return f;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] HLAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] hcnt_q, hcnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  always_comb begin
    tick   = run && (hcnt_q == HLAST);
    hcnt_d = '0;
    sclk_d = 1'b0;
    if (run) begin
      hcnt_d = tick ? '0 : hcnt_q + 1'b1;
      sclk_d = tick ? ~sclk_q : sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign rise_evt = tick & ~sclk_q;
  assign fall_evt = tick &  sclk_q;

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int START_WAIT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  sdi,
  output logic                  run,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  frame_rdy
);

  typedef enum logic [2:0] {ST_WAIT, ST_CMD, ST_DATA, ST_PARK, ST_IDLE} seq_state_t;

  localparam int WW = $clog2(START_WAIT + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam logic [WW-1:0] WLAST      = WW'(START_WAIT - 1);
  localparam logic [BW-1:0] CMD_LAST   = BW'(CMD_BITS - 1);
  localparam logic [BW-1:0] FRAME_LAST = BW'(FRAME_BITS - 1);

  seq_state_t            state_q, state_d;
  logic [WW-1:0]         wcnt_q, wcnt_d;
  logic [BW-1:0]         bcnt_q, bcnt_d;
  logic [CMD_BITS-1:0]   cmd_q, cmd_d;
  logic                  oe_q, oe_d;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic                  rdy_q, rdy_d;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    bcnt_d  = bcnt_q;
    cmd_d   = cmd_q;
    oe_d    = oe_q;
    shreg_d = shreg_q;
    rdy_d   = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (wcnt_q == WLAST) begin
          state_d = ST_CMD;
          oe_d    = 1'b1;
          cmd_d   = READ_CMD;
          bcnt_d  = '0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_CMD: begin
        if (fall_evt) begin
          cmd_d = {cmd_q[CMD_BITS-2:0], 1'b0};
          if (bcnt_q == CMD_LAST) begin
            state_d = ST_DATA;
            oe_d    = 1'b0;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (rise_evt) begin
          shreg_d = {shreg_q[FRAME_BITS-2:0], sdi};
          if (bcnt_q == FRAME_LAST) begin
            state_d = ST_PARK;
            rdy_d   = 1'b1;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_PARK: begin
        if (fall_evt) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      wcnt_q  <= '0;
      bcnt_q  <= '0;
      cmd_q   <= '0;
      oe_q    <= 1'b0;
      shreg_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      bcnt_q  <= bcnt_d;
      cmd_q   <= cmd_d;
      oe_q    <= oe_d;
      shreg_q <= shreg_d;
      rdy_q   <= rdy_d;
    end
  end

  assign run       = (state_q == ST_CMD) || (state_q == ST_DATA) || (state_q == ST_PARK);
  assign sdo       = oe_q & cmd_q[CMD_BITS-1];
  assign sdo_oe    = oe_q;
  assign frame     = shreg_q;
  assign frame_rdy = rdy_q;

endmodule

// File: rtl/cfg_field_reg.sv
module cfg_field_reg
  import cfg_loader_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic [FRAME_BITS-1:0] frame,
  output cfg_fields_t           cfg,
  output logic                  done,
  output logic                  valid
);

  logic [7:0]  byte_w [FRAME_BYTES];
  cfg_fields_t cfg_q, cfg_d;
  logic        done_q, done_d;
  logic        valid_q, valid_d;
  logic        frame_ok;

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_bytes
    assign byte_w[g] = frame[(FRAME_BYTES-g)*8-1 -: 8];
  end

  assign frame_ok = (byte_w[0] == MARK_HEAD) && (byte_w[FRAME_BYTES-1] == MARK_TAIL);

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = valid_q;
    done_d  = apply;
    if (apply) begin
      if (frame_ok) begin
        cfg_d   = decode_cfg(byte_w[1], byte_w[2], byte_w[3], byte_w[4]);
        valid_d = 1'b1;
      end else begin
        cfg_d   = CFG_DEFAULT;
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_DEFAULT;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  assign cfg   = cfg_q;
  assign done  = done_q;
  assign valid = valid_q;

endmodule

// File: rtl/cfg_prom_loader.sv
module cfg_prom_loader
  import cfg_loader_pkg::*;
#(
  parameter int HALF_DIV    = 8,
  parameter int START_WAIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  output logic       sclk,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       sdi,
  output logic       load_done,
  output logic       load_valid,
  output logic [2:0] cfg_pre_delay,
  output logic       cfg_up_ded_n,
  output logic       cfg_up_emb_n,
  output logic       cfg_bw_full,
  output logic       cfg_wait_en,
  output logic [1:0] cfg_px_width,
  output logic [1:0] cfg_ctrl_mode,
  output logic       cfg_clk_rise,
  output logic [1:0] cfg_up_clk_sel,
  output logic [3:0] cfg_recov,
  output logic [2:0] cfg_err_mode,
  output logic       cfg_pll_rst_dis
);

  logic                  rst_int_n;
  logic                  run;
  logic                  rise_evt;
  logic                  fall_evt;
  logic [FRAME_BITS-1:0] frame;
  logic                  frame_rdy;
  cfg_fields_t           cfg_w;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  cfg_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk_gen (
    .clk      (clk_ref),
    .rst_n    (rst_int_n),
    .run      (run),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cfg_seq_ctrl #(.START_WAIT(START_WAIT)) u_seq_ctrl (
    .clk       (clk_ref),
    .rst_n     (rst_int_n),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .sdi       (sdi),
    .run       (run),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .frame     (frame),
    .frame_rdy (frame_rdy)
  );

  cfg_field_reg u_field_reg (
    .clk   (clk_ref),
    .rst_n (rst_int_n),
    .apply (frame_rdy),
    .frame (frame),
    .cfg   (cfg_w),
    .done  (load_done),
    .valid (load_valid)
  );

  assign cfg_pre_delay   = cfg_w.pre_delay;
  assign cfg_up_ded_n    = cfg_w.up_ded_n;
  assign cfg_up_emb_n    = cfg_w.up_emb_n;
  assign cfg_bw_full     = cfg_w.bw_full;
  assign cfg_wait_en     = cfg_w.wait_en;
  assign cfg_px_width    = cfg_w.px_width;
  assign cfg_ctrl_mode   = cfg_w.ctrl_mode;
  assign cfg_clk_rise    = cfg_w.clk_rise;
  assign cfg_up_clk_sel  = cfg_w.up_clk_sel;
  assign cfg_recov       = cfg_w.recov;
  assign cfg_err_mode    = cfg_w.err_mode;
  assign cfg_pll_rst_dis = cfg_w.pll_rst_dis;

endmodule

// File: rtl/cfg_prom_loader_chk.sv
module cfg_prom_loader_chk #(
  parameter int HALF_DIV   = 8,
  parameter int START_WAIT = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        sdo,
  input logic        sdo_oe,
  input logic        load_done,
  input logic        load_valid,
  input logic [21:0] fields
);

  logic [15:0] hi_cnt_q;
  logic [15:0] since_q;
  logic        seen_rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q    <= '0;
      since_q     <= '0;
      seen_rise_q <= 1'b0;
    end else begin
      hi_cnt_q <= sclk ? hi_cnt_q + 16'd1 : 16'd0;
      if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
      if (sclk) seen_rise_q <= 1'b1;
    end
  end

  AST_START_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !seen_rise_q) |-> (since_q >= 16'(START_WAIT))); // R2

  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt_q == 16'(HALF_DIV))); // R3

  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo)); // R4

  AST_OE_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !sdo_oe); // R5

  AST_VALID_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_valid) |-> load_done); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done); // R9

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> ($stable(fields) && $stable(load_valid))); // R10

endmodule

bind cfg_prom_loader cfg_prom_loader_chk #(
  .HALF_DIV   (HALF_DIV),
  .START_WAIT (START_WAIT)
) u_chk (
  .clk        (clk_ref),
  .rst_n      (rst_n),
  .sclk       (sclk),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .load_done  (load_done),
  .load_valid (load_valid),
  .fields     (cfg_w)
);

// File: tb/test_cfg_prom_loader.sv
module test_cfg_prom_loader;

  localparam int HALF_DIV   = 8;
  localparam int START_WAIT = 8;
  localparam logic [21:0] DEF = {3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b11,
                                 1'b1, 2'b10, 4'b0001, 3'b000, 1'b0};

  logic clk_ref = 1'b0;
  always #10 clk_ref = ~clk_ref;

  logic       rst_n = 1'b0;
  logic       sdi = 1'b0;
  logic       sclk, sdo, sdo_oe, load_done, load_valid;
  logic [2:0] cfg_pre_delay, cfg_err_mode;
  logic       cfg_up_ded_n, cfg_up_emb_n, cfg_bw_full, cfg_wait_en, cfg_clk_rise, cfg_pll_rst_dis;
  logic [1:0] cfg_px_width, cfg_ctrl_mode, cfg_up_clk_sel;
  logic [3:0] cfg_recov;

  cfg_prom_loader #(.HALF_DIV(HALF_DIV), .START_WAIT(START_WAIT)) i_cfg_prom_loader (
    .clk_ref(clk_ref), .rst_n(rst_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi),
    .load_done(load_done), .load_valid(load_valid),
    .cfg_pre_delay(cfg_pre_delay), .cfg_up_ded_n(cfg_up_ded_n), .cfg_up_emb_n(cfg_up_emb_n),
    .cfg_bw_full(cfg_bw_full), .cfg_wait_en(cfg_wait_en), .cfg_px_width(cfg_px_width),
    .cfg_ctrl_mode(cfg_ctrl_mode), .cfg_clk_rise(cfg_clk_rise), .cfg_up_clk_sel(cfg_up_clk_sel),
    .cfg_recov(cfg_recov), .cfg_err_mode(cfg_err_mode), .cfg_pll_rst_dis(cfg_pll_rst_dis)
  );

  wire [21:0] got = {cfg_pre_delay, cfg_up_ded_n, cfg_up_emb_n, cfg_bw_full, cfg_wait_en,
                     cfg_px_width, cfg_ctrl_mode, cfg_clk_rise, cfg_up_clk_sel, cfg_recov,
                     cfg_err_mode, cfg_pll_rst_dis};

  int vec_cnt = 0;
  int err_cnt = 0;
  int done_seen = 0;
  int bad_phase = 0;
  int since_rel = 0;
  int rise_at = -1;
  logic [22:0] exp_q[$];

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected {valid, settings} from the frame, per R7/R8 bit positions
  function automatic logic [22:0] expect_of(input logic [47:0] f);
    logic [7:0] b1, b2, b3, b4;
    b1 = f[39:32]; b2 = f[31:24]; b3 = f[23:16]; b4 = f[15:8];
    if (f[47:40] == 8'hBD && f[7:0] == 8'h99)
      return {1'b1, b1[2:0], b1[3], b1[4], b1[6], b1[7], b2[1:0], b2[3:2], b2[5],
              b2[7:6], b3[3:0], b3[7:5], b4[0]};
    return {1'b0, DEF};
  endfunction

  // scoreboard monitor
  always @(negedge clk_ref) begin
    if (rst_n && load_done) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        check(64'd1, 64'd0, "R9 unexpected done");
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        check({41'd0, load_valid, got}, {41'd0, e}, e[22] ? "R6 R7 loaded settings" : "R8 defaults");
      end
    end
  end

  // phase length and start delay tracking
  logic prev_sclk = 1'b0;
  logic after_fall = 1'b0;
  int   run_len = 0;
  always @(negedge clk_ref) begin
    if (!rst_n) begin
      prev_sclk = 1'b0; after_fall = 1'b0; run_len = 0; since_rel = 0; rise_at = -1;
    end else begin
      since_rel++;
      if (sclk && rise_at < 0) rise_at = since_rel;
      if (sclk != prev_sclk) begin
        if (prev_sclk && run_len != HALF_DIV) bad_phase++;
        if (!prev_sclk && after_fall && run_len != HALF_DIV) bad_phase++;
        after_fall = prev_sclk;
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_sclk = sclk;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    sdi = 1'b0;
    repeat (4) @(posedge clk_ref);
    @(negedge clk_ref);
    check({59'd0, sclk, sdo_oe, load_done, load_valid, 1'b0}, 64'd0, "R1 reset controls");
    check({42'd0, got}, {42'd0, DEF}, "R1 reset defaults");
    rst_n = 1'b1;
  endtask

  // PROM model: reads the command, then answers with up to limit bits
  task automatic prom_host(input logic [47:0] f, input int limit);
    logic [10:0] cmd;
    int oe_bad;
    cmd = '0;
    oe_bad = 0;
    for (int i = 0; i < 11; i++) begin
      @(posedge sclk); #2;
      cmd = {cmd[9:0], sdo};
      if (!sdo_oe) oe_bad++;
    end
    check({53'd0, cmd}, {53'd0, 11'b110_0000_0000}, "R4 command bits");
    check(oe_bad, 0, "R4 oe during command");
    oe_bad = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge sclk); #2;
      sdi = f[47-i];
      if (sdo_oe) oe_bad++;
    end
    check(oe_bad, 0, "R5 oe released in reply");
  endtask

  task automatic full_load(input logic [47:0] f);
    int n0;
    logic [22:0] e;
    e = expect_of(f);
    exp_q.push_back(e);
    n0 = done_seen;
    bad_phase = 0;
    do_reset();
    prom_host(f, 48);
    while (done_seen == n0) @(negedge clk_ref);
    repeat (3 * HALF_DIV) @(negedge clk_ref);
    check({62'd0, sclk, sdo_oe}, 64'd0, "R10 clock parked after load");
    check({41'd0, load_valid, got}, {41'd0, e}, "R10 settings held after load");
    check(done_seen, n0 + 1, "R9 one done per reset");
    check(bad_phase, 0, "R3 phase lengths");
    check(rise_at >= START_WAIT, 1, "R2 start delay");
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    full_load({8'hBD, 8'h5A, 8'hC6, 8'h2B, 8'h01, 8'h99});   // R7 mixed pattern
    full_load({8'hBD, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h99});   // R7 all ones
    full_load({8'hBD, 8'h00, 8'h00, 8'h00, 8'h00, 8'h99});   // R7 all zeros
    full_load({8'hBC, 8'h5A, 8'hC6, 8'h2B, 8'h01, 8'h99});   // R8 bad head
    full_load({8'hBD, 8'h5A, 8'hC6, 8'h2B, 8'h01, 8'h98});   // R8 bad tail
    // R11: reset part way through the reply
    do_reset();
    prom_host({8'hBD, 8'hA5, 8'h39, 8'hD4, 8'hFE, 8'h99}, 20);
    repeat (5) @(negedge clk_ref);
    check({41'd0, load_valid, got}, {41'd0, 1'b0, DEF}, "R10 no partial apply");
    rst_n = 1'b0;
    #1;
    check({61'd0, sclk, sdo_oe, load_valid}, 64'd0, "R11 abort to reset state");
    check({42'd0, got}, {42'd0, DEF}, "R11 defaults on abort");
    full_load({8'hBD, 8'hA5, 8'h39, 8'hD4, 8'hFE, 8'h99});   // R11 fresh load
    check(exp_q.size(), 0, "R9 all loads reported");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule